// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an asynchronous 128K x 8 static RAM. A client offers one access at a time on a valid/ready handshake: a 17-bit word address, a write flag and a byte of write data. The controller then produces the memory's control pins: a low-true select, a high-true select, a low-true write strobe and a low-true output enable. It also produces the address, the outgoing data byte and an enable for the tri-state data bus. Read data comes back with a one-cycle valid pulse.

Every phase of an access lasts a whole number of clock cycles. Each count is derived at elaboration from nanosecond timing parameters and a clock-period parameter, rounding up. Writes are strobe-controlled: the selects and the address settle first, the write strobe is pulsed, and the bus is still driven for at least one cycle after the strobe rises. A retention handshake parks the memory deselected while its supply is lowered. Once the request is withdrawn, new accesses are held off for a recovery time.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `ret_active` is 0, and the memory is in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: In a write, both selects are active and `mem_addr` is stable on every busy cycle. Busy cycles are counted from the cycle after acceptance until `req_ready` returns. `mem_we_n` is low for exactly PULSE cycles, where PULSE = max(1, ceil(tWP), ceil(tDW)-SETUP, ceil(tAW)-SETUP, ceil(tCW)-SETUP) and SETUP = max(1, ceil(tAS)). The memory stores `req_wdata` at `req_addr`. Here ceil(t) means ceil(t / clock period).
- R3: `mem_dq_oe` is high on every busy cycle of a write, including at least one cycle after `mem_we_n` rises. It is never high while both selects are active with `mem_oe_n`=0 and `mem_we_n`=1.
- R4: A write keeps `req_ready` low for SETUP + PULSE + HOLD cycles, where HOLD = max(1, ceil(tWR), ceil(tDH), ceil(tWC)-SETUP-PULSE). That is 6 cycles with the default parameters.
- R5: In a read, both selects are active and `mem_oe_n` is low for exactly ACC = max(1, ceil(tAA), ceil(tOE)) cycles. The bus is sampled at the end of that window. `rsp_valid` is then high for one cycle with the sampled byte on `rsp_rdata`.
- R6: A read keeps `req_ready` low for ACC + TAIL cycles, where TAIL = max(1, ceil(tHZ), ceil(tRC)-ACC). That is 8 cycles with the default parameters.
- R7: Whenever `req_ready` is 1, the memory is in standby with the strobes inactive and the bus released.
- R8: `ret_req` is acted on only when the controller is idle. An access in progress finishes first. In retention `ret_active`=1, `mem_cs1_n`=1 and `req_ready`=0, and `req_valid` starts no memory cycle.
- R9: After `ret_req` falls, `ret_active` drops on the next cycle. `req_ready` then stays low for RCV = max(1, ceil(tR)) cycles, which is 6 with the defaults.
- R10: If `ret_req` and `req_valid` are both high while idle, retention wins and the request is not accepted. The memory contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous low-true reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| ret_req | input | 1 | Ask to park the memory for retention |
| ret_active | output | 1 | Memory is parked for retention |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Low-true chip select |
| mem_cs2 | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_i | input | 8 | Byte read from the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach from the ports is a retention request that arrives while a write strobe is already low, because the controller must finish that write unharmed before parking. The bench raises `ret_req` two cycles into a write and checks the full strobe width, the select hold and the idle gap before retention. It then reads the byte back after recovery. The memory model in the bench returns a garbage byte until the address has been in read mode for the access count, so a sample taken one cycle early is caught.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTAIL  = 3'd5,
    ST_RET    = 3'd6,
    ST_RCV    = 3'd7
  } seq_state_t;

  // Nanoseconds to whole clock cycles, rounding up.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    if (ns <= 0) return 0;
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least_one(input int a);
    return imax(a, 1);
  endfunction

  // Write-strobe length: covers strobe width and the data, address and
  // select windows that end with the strobe, minus the setup phase.
  function automatic int pulse_cycles(input int wp, input int dw,
                                      input int aw, input int cw,
                                      input int setup);
    int r;
    r = imax(1, wp);
    r = imax(r, dw - setup);
    r = imax(r, aw - setup);
    r = imax(r, cw - setup);
    return r;
  endfunction

  // Post-strobe hold: recovery, data hold, and padding to the cycle time.
  function automatic int hold_cycles(input int wr, input int dh,
                                     input int wc, input int setup,
                                     input int pulse);
    int r;
    r = imax(1, wr);
    r = imax(r, dh);
    r = imax(r, wc - setup - pulse);
    return r;
  endfunction

  function automatic int access_cycles(input int aa, input int oe);
    return imax(1, imax(aa, oe));
  endfunction

  // Read tail: bus turnaround and padding to the read cycle time.
  function automatic int tail_cycles(input int hz, input int rc, input int acc);
    return imax(1, imax(hz, rc - acc));
  endfunction

  function automatic bit is_select_state(input seq_state_t s);
    return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD) ||
           (s == ST_RACC);
  endfunction

  function automatic bit is_write_state(input seq_state_t s);
    return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SETUP_LEN = 1,
  parameter int PULSE_LEN = 4,
  parameter int HOLD_LEN  = 1,
  parameter int ACC_LEN   = 6,
  parameter int TAIL_LEN  = 2,
  parameter int RCV_LEN   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_we,
  input  logic       ret_req,
  output seq_state_t state,
  output seq_state_t nxt_state,
  output logic       phase_done,
  output logic       accept,
  output logic       idle_free
);

  seq_state_t       state_q;
  seq_state_t       nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;

  function automatic logic [CNT_W-1:0] phase_len_m1(input seq_state_t s);
    case (s)
      ST_WSETUP: return CNT_W'(SETUP_LEN - 1);
      ST_WPULSE: return CNT_W'(PULSE_LEN - 1);
      ST_WHOLD:  return CNT_W'(HOLD_LEN - 1);
      ST_RACC:   return CNT_W'(ACC_LEN - 1);
      ST_RTAIL:  return CNT_W'(TAIL_LEN - 1);
      ST_RCV:    return CNT_W'(RCV_LEN - 1);
      default:   return '0;
    endcase
  endfunction

  assign idle_free = (state_q == ST_IDLE) && !ret_req;
  assign accept    = idle_free && req_valid;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ret_req)        nxt = ST_RET;
        else if (req_valid) nxt = req_we ? ST_WSETUP : ST_RACC;
      end
      ST_WSETUP: if (phase_done) nxt = ST_WPULSE;
      ST_WPULSE: if (phase_done) nxt = ST_WHOLD;
      ST_WHOLD:  if (phase_done) nxt = ST_IDLE;
      ST_RACC:   if (phase_done) nxt = ST_RTAIL;
      ST_RTAIL:  if (phase_done) nxt = ST_IDLE;
      ST_RET:    if (!ret_req)   nxt = ST_RCV;
      ST_RCV:    if (phase_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign load     = (nxt != state_q);
  assign load_val = phase_len_m1(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .done     (phase_done)
  );

  assign state     = state_q;
  assign nxt_state = nxt;

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        nxt_state,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  // Pins are registered from the next state so they change cleanly on
  // the same edge as the state register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n <= 1'b1;
      mem_cs2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs1_n <= !is_select_state(nxt_state);
      mem_cs2   <=  is_select_state(nxt_state);
      mem_we_n  <= (nxt_state != ST_WPULSE);
      mem_oe_n  <= (nxt_state != ST_RACC);
      mem_dq_oe <=  is_write_state(nxt_state);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic              phase_done,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic sample_now;
  assign sample_now = (state == ST_RACC) && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample_now;
      if (sample_now) rsp_rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_CW_NS   = 45,
  parameter int T_AW_NS   = 45,
  parameter int T_AS_NS   = 0,
  parameter int T_WR_NS   = 0,
  parameter int T_DW_NS   = 25,
  parameter int T_DH_NS   = 0,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_HZ_NS   = 20,
  parameter int T_RCV_NS  = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic              ret_active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int SETUP_LEN = at_least_one(ns_to_cyc(T_AS_NS, CLK_NS));
  localparam int PULSE_LEN = pulse_cycles(ns_to_cyc(T_WP_NS, CLK_NS),
                                          ns_to_cyc(T_DW_NS, CLK_NS),
                                          ns_to_cyc(T_AW_NS, CLK_NS),
                                          ns_to_cyc(T_CW_NS, CLK_NS),
                                          SETUP_LEN);
  localparam int HOLD_LEN  = hold_cycles(ns_to_cyc(T_WR_NS, CLK_NS),
                                         ns_to_cyc(T_DH_NS, CLK_NS),
                                         ns_to_cyc(T_WC_NS, CLK_NS),
                                         SETUP_LEN, PULSE_LEN);
  localparam int ACC_LEN   = access_cycles(ns_to_cyc(T_AA_NS, CLK_NS),
                                           ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int TAIL_LEN  = tail_cycles(ns_to_cyc(T_HZ_NS, CLK_NS),
                                         ns_to_cyc(T_RC_NS, CLK_NS), ACC_LEN);
  localparam int RCV_LEN   = at_least_one(ns_to_cyc(T_RCV_NS, CLK_NS));

  seq_state_t state;
  seq_state_t nxt_state;
  logic       phase_done;
  logic       accept;
  logic       idle_free;

  // Named events for the checker
  logic       wr_window;
  logic       mem_drives;

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .SETUP_LEN (SETUP_LEN),
    .PULSE_LEN (PULSE_LEN),
    .HOLD_LEN  (HOLD_LEN),
    .ACC_LEN   (ACC_LEN),
    .TAIL_LEN  (TAIL_LEN),
    .RCV_LEN   (RCV_LEN)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .ret_req    (ret_req),
    .state      (state),
    .nxt_state  (nxt_state),
    .phase_done (phase_done),
    .accept     (accept),
    .idle_free  (idle_free)
  );

  sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (nxt_state),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .phase_done (phase_done),
    .mem_dq_i   (mem_dq_i),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign req_ready  = idle_free;
  assign ret_active = (state == ST_RET);
  assign wr_window  = !mem_cs1_n && mem_cs2 && !mem_we_n;
  assign mem_drives = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W    = 17,
  parameter int PULSE_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rsp_valid,
  input logic              ret_active,
  input logic              cs1_n,
  input logic              cs2,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              wr_window,
  input logic              mem_drives,
  input logic [ADDR_W-1:0] addr
);

  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_cnt <= '0;
    else if (!we_n) lo_cnt <= lo_cnt + 16'd1;
    else            lo_cnt <= '0;
  end

  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && mem_drives));

  // R2
  strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs1_n && cs2 && dq_oe));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_n && $past(!cs1_n)) |-> $stable(addr));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lo_cnt == 16'(PULSE_LEN)));

  // R3
  data_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_window) |-> dq_oe);

  // R5
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs1_n && !cs2 && we_n && oe_n && !dq_oe));

  // R8
  retention_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_active |-> (cs1_n && !ready && we_n));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_LEN (PULSE_LEN)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (req_ready),
  .rsp_valid  (rsp_valid),
  .ret_active (ret_active),
  .cs1_n      (mem_cs1_n),
  .cs2        (mem_cs2),
  .we_n       (mem_we_n),
  .oe_n       (mem_oe_n),
  .dq_oe      (mem_dq_oe),
  .wr_window  (wr_window),
  .mem_drives (mem_drives),
  .addr       (mem_addr)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int PER = 10;

  function automatic int up(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts restated from the requirements, default timings
  localparam int E_SETUP = mx(1, up(0));
  localparam int E_PULSE = mx(mx(mx(1, up(40)), up(25) - E_SETUP),
                              mx(up(45) - E_SETUP, up(45) - E_SETUP));
  localparam int E_HOLD  = mx(mx(1, up(0)), mx(up(0), up(55) - E_SETUP - E_PULSE));
  localparam int E_WBUSY = E_SETUP + E_PULSE + E_HOLD;
  localparam int E_ACC   = mx(1, mx(up(55), up(25)));
  localparam int E_TAIL  = mx(1, mx(up(20), up(55) - E_ACC));
  localparam int E_RBUSY = E_ACC + E_TAIL;
  localparam int E_RCV   = mx(1, up(55));
  localparam int M_AA    = up(55);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        ret_req = 1'b0;
  logic        ret_active;
  logic [16:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  int n_tests = 0;
  int n_fail  = 0;
  int bus_errs = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ret_req(ret_req), .ret_active(ret_active),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  // ---- memory model ----
  logic [7:0] mem_model [bit [16:0]];
  int         rd_age = 0;
  logic       rd_mode, wr_mode;
  assign rd_mode = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
  assign wr_mode = !mem_cs1_n && mem_cs2 && !mem_we_n;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_mode) rd_age <= rd_age + 1;
    else         rd_age <= 0;
    if (wr_mode) begin
      if (!mem_dq_oe) bus_errs <= bus_errs + 1;
      mem_model[mem_addr] = mem_dq_o;
    end
    if (mem_dq_oe && rd_mode) bus_errs <= bus_errs + 1;
  end

  always_comb begin
    if (rd_mode && (rd_age + 1 >= M_AA))
      mem_dq_i = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
    else
      mem_dq_i = 8'hEE;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(mem_cs1_n == 1'b1 && mem_cs2 == 1'b0, "R1 selects",
          int'({mem_cs1_n, mem_cs2}), 2);
    check(mem_we_n && mem_oe_n, "R1 strobes", int'({mem_we_n, mem_oe_n}), 3);
    check(!mem_dq_oe && !rsp_valid && !ret_active, "R1 bus/rsp/ret",
          int'({mem_dq_oe, rsp_valid, ret_active}), 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int busy = 0, welow = 0, sel = 0, oecnt = 0;
    bit addr_ok = 1;
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    while (!req_ready && busy < 100) begin
      busy++;
      if (!mem_we_n) welow++;
      if (!mem_cs1_n && mem_cs2) sel++;
      if (mem_dq_oe) oecnt++;
      if (mem_addr != a) addr_ok = 0;
      @(negedge clk);
    end
    check(busy == E_WBUSY, "R4 write busy", busy, E_WBUSY);
    check(welow == E_PULSE, "R2 strobe width", welow, E_PULSE);
    check(sel == E_WBUSY && addr_ok, "R2 selects/addr held", sel, E_WBUSY);
    check(oecnt == E_WBUSY, "R3 bus drive cycles", oecnt, E_WBUSY);
    check(mem_model.exists(a) && mem_model[a] == d, "R2 stored byte",
          mem_model.exists(a) ? int'(mem_model[a]) : -1, int'(d));
    check(mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R7 standby after write",
          int'({mem_cs1_n, mem_cs2, mem_dq_oe}), 4);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
    int busy = 0, oelow = 0, nrsp = 0;
    logic [7:0] got = 8'h00;
    req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_addr = ~a;
    while (!req_ready && busy < 100) begin
      busy++;
      if (!mem_oe_n && !mem_cs1_n && mem_cs2) oelow++;
      if (rsp_valid) begin nrsp++; got = rsp_rdata; end
      @(negedge clk);
    end
    check(oelow == E_ACC, "R5 output-enable window", oelow, E_ACC);
    check(nrsp == 1, "R5 one response", nrsp, 1);
    check(got == exp, "R5 read data", int'(got), int'(exp));
    check(busy == E_RBUSY, "R6 read busy", busy, E_RBUSY);
    check(bus_errs == 0, "R3 no contention", bus_errs, 0);
  endtask

  task automatic wait_recover(input string tag);
    int n = 0;
    ret_req = 0;
    @(negedge clk);
    check(!ret_active, "R9 ret_active drops", int'(ret_active), 0);
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == E_RCV, tag, n, E_RCV);
  endtask

  task automatic t_retention_basic();
    ret_req = 1;
    @(negedge clk);
    check(ret_active && mem_cs1_n && !req_ready, "R8 parked",
          int'({ret_active, mem_cs1_n, req_ready}), 6);
    // a request while parked must start no cycle
    req_valid = 1; req_we = 1; req_addr = 17'h00010; req_wdata = 8'h99;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(mem_cs1_n && mem_we_n, "R8 request ignored while parked",
            int'({mem_cs1_n, mem_we_n}), 3);
    end
    req_valid = 0;
    wait_recover("R9 recovery length");
    do_read(17'h00010, 8'h3C);
  endtask

  task automatic t_retention_mid_write();
    int n = 0, welow = 0, sel = 0;
    req_valid = 1; req_we = 1; req_addr = 17'h0BEEF; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 0;
    while (!ret_active && n < 100) begin
      n++;
      if (n == 2) ret_req = 1;
      if (!mem_we_n) welow++;
      if (!mem_cs1_n && mem_cs2) sel++;
      @(negedge clk);
    end
    check(n == E_WBUSY + 1, "R8 write finishes before parking", n, E_WBUSY + 1);
    check(welow == E_PULSE && sel == E_WBUSY, "R8 write undisturbed",
          welow, E_PULSE);
    wait_recover("R9 recovery after mid-write request");
    do_read(17'h0BEEF, 8'h77);
  endtask

  task automatic t_priority();
    ret_req = 1; req_valid = 1; req_we = 1; req_addr = 17'h00020; req_wdata = 8'h11;
    #1;
    check(!req_ready, "R10 not ready with ret_req", int'(req_ready), 0);
    @(negedge clk);
    check(ret_active && mem_we_n && mem_cs1_n, "R10 retention wins",
          int'({ret_active, mem_we_n, mem_cs1_n}), 7);
    req_valid = 0;
    wait_recover("R9 recovery after priority");
    do_read(17'h00020, 8'hC4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    do_write(17'h00010, 8'h3C);
    do_write(17'h1FFFF, 8'hFF);
    do_write(17'h00000, 8'h00);
    do_write(17'h00020, 8'hC4);
    do_read(17'h1FFFF, 8'hFF);
    do_read(17'h00000, 8'h00);
    do_write(17'h0A5A5, 8'hA5);
    do_read(17'h0A5A5, 8'hA5);
    do_read(17'h00010, 8'h3C);
    t_retention_basic();
    t_retention_mid_write();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (R1..) actual=%0d expected=<20000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule